// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a single-port synchronous static memory of 32-bit words, built so that a memory controller or a processor bus can fetch or fill a four-word block with one address. Every input is sampled on the rising clock edge. A read comes out of a two-register pipeline behind the sampled request. After a start address is loaded, a 2-bit beat counter walks the rest of the four-word block in one of two orders. A mode input picks between counting upward and XOR stepping. The upper address bits stay fixed for the whole burst.

Either of two strobes loads a new burst: one meant for the processor side and one meant for the controller side. An advance input steps the burst on. Byte enables and a whole-word write enable commit writes in the cycle after they are sampled, with no outside write timing. Three chip selects support depth expansion. A newly selected device drives data two edges after its load. A deselected device stops driving one edge after its deselecting load, so two banks sharing a bus never overlap. The output enable gates the drivers without waiting for a clock. A sleep input stops all accesses and blanks the outputs while keeping the stored words.

All controls are active high. The depth is set by the address-width parameter, so the memory stays small in simulation. The three-state bus is modelled as a data word plus a drive flag, and the data word reads zero whenever it is not driven.

Top module: `sbsram_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, rdata_en is 0 and rdata is 0.
- R2: A read is accepted at edge k in either of two cases: a selected load, or an advance of a live burst with no write enable. Its word appears with rdata_en=1 after edge k+2 and not after edge k+1.
- R3: With lin_mode=0, beat n of a burst (n = 0..3) reads address {start[ADDR_W-1:2], start[1:0] XOR n}.
- R4: With lin_mode=1, beat n reads address {start[ADDR_W-1:2], (start[1:0] + n) mod 4}.
- R5: An advance after the fourth beat wraps to the beat-0 address of the same four-word block. The upper address bits never change.
- R6: In a cycle with no accepted load and all_we=0, a live burst writes when any byte_we bit is set. Bit i selects data bits 8i+7..8i. Only the selected bytes change. With adv=0 the write goes to the current beat address. With adv=1 it goes to the next beat. Write cycles produce no output word.
- R7: all_we=1 writes all four bytes, whatever byte_we holds.
- R8: strobe_cpu is ignored while ce_a=0: nothing is accessed and the live burst continues unchanged. With ce_a=1 it loads addr.
- R9: strobe_ctl always loads, whatever ce_a is. The new burst is selected only if ce_a, ce_b and ce_c are all 1. An unselected load ends the burst, so later advances access nothing. Every load cycle is a read, even when write enables are high.
- R10: An unselected load sampled at edge k forces rdata_en to 0 after edge k+1. This drops the read that was accepted at edge k-1.
- R11: oe=0 forces rdata_en=0 and rdata=0 at once, without a clock edge.
- R12: While sleep=1, rdata_en is 0, no load, read or write is accepted, and stored words and burst state are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Burst start address, sampled with a load |
| strobe_cpu | input | 1 | Processor-side load strobe, honoured only with ce_a=1 |
| strobe_ctl | input | 1 | Controller-side load strobe, always honoured |
| adv | input | 1 | Step the live burst to its next beat |
| lin_mode | input | 1 | Burst order: 1 = linear, 0 = interleaved |
| byte_we | input | DATA_W/8 | Per-byte write enables; bit i covers bits 8i+7..8i |
| all_we | input | 1 | Write the whole word regardless of byte_we |
| wdata | input | DATA_W | Write data, sampled with the write cycle |
| ce_a | input | 1 | Primary chip select |
| ce_b | input | 1 | Second chip select |
| ce_c | input | 1 | Third chip select |
| oe | input | 1 | Output enable, combinational |
| sleep | input | 1 | Power-down request |
| rdata | output | DATA_W | Read word; zero when not driven |
| rdata_en | output | 1 | Bus drive flag for rdata |

## Verification
The properties assume that every control input is a known value and changes only between rising edges. They also assume reset is high from time zero until the first edges have cleared the pipeline. The cycle counts in the deselect and ignored-strobe properties rely on sleep staying low over their whole window. The stimulus changes each input on the falling edge and raises sleep only between whole cycles. It also keeps sleep low for the three cycles after every deselecting load or ignored processor strobe.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int BYTE_W = 8;
    localparam int BEATS  = 4;
    localparam int BEAT_W = $clog2(BEATS);

    // What the current cycle does to the burst state
    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_LOAD,
        ACC_STEP,
        ACC_HOLD
    } acc_e;

    // Control half of the registered request
    typedef struct packed {
        logic vld;   // memory access this cycle
        logic wr;    // access is a write
        logic kill;  // deselecting load: drop the read in flight
    } req_ctl_t;

    // Low address bits of a beat for either burst order
    function automatic logic [BEAT_W-1:0] burst_lo(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              linear
    );
        logic [BEAT_W-1:0] sum;
        sum = start + beat;
        return linear ? sum : (start ^ beat);
    endfunction

endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
)
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     strobe_cpu,
    input  logic                     strobe_ctl,
    input  logic                     adv,
    input  logic                     lin_mode,
    input  logic [DATA_W/BYTE_W-1:0] byte_we,
    input  logic                     all_we,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     ce_a,
    input  logic                     ce_b,
    input  logic                     ce_c,
    input  logic                     sleep,
    output req_ctl_t                 req,
    output logic [ADDR_W-1:0]        req_addr,
    output logic [DATA_W/BYTE_W-1:0] req_be,
    output logic [DATA_W-1:0]        req_wdata
);

    localparam int NB = DATA_W / BYTE_W;

    logic [ADDR_W-1:BEAT_W] blk_q;
    logic [BEAT_W-1:0]      start_q;
    logic [BEAT_W-1:0]      beat_q;
    logic [BEAT_W-1:0]      beat_nx;
    logic                   live_q;
    logic                   sel;
    logic                   load;
    logic                   any_we;
    logic [NB-1:0]          be;
    logic [ADDR_W-1:0]      acc_addr;
    acc_e                   kind;

    always_comb begin
        sel     = ce_a & ce_b & ce_c;
        load    = (strobe_cpu & ce_a) | strobe_ctl;
        any_we  = all_we | (|byte_we);
        be      = all_we ? {NB{1'b1}} : byte_we;
        beat_nx = beat_q + 1'b1;

        if (sleep)                 kind = ACC_NONE;
        else if (load)             kind = ACC_LOAD;
        else if (live_q && adv)    kind = ACC_STEP;
        else if (live_q && any_we) kind = ACC_HOLD;
        else                       kind = ACC_NONE;

        case (kind)
            ACC_LOAD: acc_addr = addr;
            ACC_STEP: acc_addr = {blk_q, burst_lo(start_q, beat_nx, lin_mode)};
            default:  acc_addr = {blk_q, burst_lo(start_q, beat_q, lin_mode)};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q     <= '0;
            start_q   <= '0;
            beat_q    <= '0;
            live_q    <= 1'b0;
            req       <= '0;
            req_addr  <= '0;
            req_be    <= '0;
            req_wdata <= '0;
        end else begin
            req.vld   <= ((kind == ACC_LOAD) && sel) ||
                         (kind == ACC_STEP) || (kind == ACC_HOLD);
            req.wr    <= ((kind == ACC_STEP) || (kind == ACC_HOLD)) && any_we;
            req.kill  <= (kind == ACC_LOAD) && !sel;
            req_addr  <= acc_addr;
            req_be    <= be;
            req_wdata <= wdata;
            if (kind == ACC_LOAD) begin
                blk_q   <= addr[ADDR_W-1:BEAT_W];
                start_q <= addr[BEAT_W-1:0];
                beat_q  <= '0;
                live_q  <= sel;
            end else if (kind == ACC_STEP) begin
                beat_q  <= beat_nx;
            end
        end
    end

endmodule

// File: rtl/sbsram_bank.sv
module sbsram_bank
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
)
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [DATA_W/BYTE_W-1:0] acc_be,
    input  logic [DATA_W-1:0]        acc_wdata,
    output logic                     rd_vld,
    output logic [DATA_W-1:0]        rd_data
);

    localparam int NB    = DATA_W / BYTE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] wmask;

    for (genvar b = 0; b < NB; b++) begin : g_mask
        assign wmask[b*BYTE_W +: BYTE_W] = {BYTE_W{acc_be[b]}};
    end

    // Self-timed commit: the registered write lands on the next edge
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[acc_addr] <= (mem[acc_addr] & ~wmask) | (acc_wdata & wmask);
        end
        rd_data <= mem[acc_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) rd_vld <= 1'b0;
        else     rd_vld <= rd_en;
    end

endmodule

// File: rtl/sbsram_top.sv
module sbsram_top
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
)
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     strobe_cpu,
    input  logic                     strobe_ctl,
    input  logic                     adv,
    input  logic                     lin_mode,
    input  logic [DATA_W/BYTE_W-1:0] byte_we,
    input  logic                     all_we,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     ce_a,
    input  logic                     ce_b,
    input  logic                     ce_c,
    input  logic                     oe,
    input  logic                     sleep,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_en
);

    localparam int NB = DATA_W / BYTE_W;

    req_ctl_t          req;
    logic [ADDR_W-1:0] req_addr;
    logic [NB-1:0]     req_be;
    logic [DATA_W-1:0] req_wdata;
    logic              rd_vld;
    logic [DATA_W-1:0] rd_data;
    logic              out_vld_q;
    logic [DATA_W-1:0] out_data_q;
    logic              bank_wr;
    logic              bank_rd;

    sbsram_burst #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_burst (
        .clk        (clk),
        .rst        (rst),
        .addr       (addr),
        .strobe_cpu (strobe_cpu),
        .strobe_ctl (strobe_ctl),
        .adv        (adv),
        .lin_mode   (lin_mode),
        .byte_we    (byte_we),
        .all_we     (all_we),
        .wdata      (wdata),
        .ce_a       (ce_a),
        .ce_b       (ce_b),
        .ce_c       (ce_c),
        .sleep      (sleep),
        .req        (req),
        .req_addr   (req_addr),
        .req_be     (req_be),
        .req_wdata  (req_wdata)
    );

    assign bank_wr = req.vld & req.wr;
    assign bank_rd = req.vld & ~req.wr;

    sbsram_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bank_wr),
        .rd_en     (bank_rd),
        .acc_addr  (req_addr),
        .acc_be    (req_be),
        .acc_wdata (req_wdata),
        .rd_vld    (rd_vld),
        .rd_data   (rd_data)
    );

    // Second pipeline stage; a deselecting load cuts the pending word
    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld_q  <= 1'b0;
            out_data_q <= '0;
        end else begin
            out_vld_q  <= rd_vld & ~req.kill;
            out_data_q <= rd_data;
        end
    end

    assign rdata_en = out_vld_q & oe & ~sleep;
    assign rdata    = rdata_en ? out_data_q : '0;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
    parameter int DATA_W = 32
)
(
    input logic                clk,
    input logic                rst,
    input logic                strobe_cpu,
    input logic                strobe_ctl,
    input logic                adv,
    input logic [DATA_W/8-1:0] byte_we,
    input logic                all_we,
    input logic                ce_a,
    input logic                ce_b,
    input logic                ce_c,
    input logic                oe,
    input logic                sleep,
    input logic [DATA_W-1:0]   rdata,
    input logic                rdata_en
);

    // R1
    r1_reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!rdata_en && rdata == '0));

    // R11
    r11_oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !oe |-> (!rdata_en && rdata == '0));

    // R12
    r12_sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !rdata_en);

    // R10
    r10_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_ctl && !sleep && !(ce_a && ce_b && ce_c)) |-> ##2 !rdata_en);

    // R8
    r8_ignored_load_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_cpu && !ce_a && !strobe_ctl && !adv && !all_we &&
         byte_we == '0 && !sleep) |-> ##3 !rdata_en);

endmodule

bind sbsram_top sbsram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .adv        (adv),
    .byte_we    (byte_we),
    .all_we     (all_we),
    .ce_a       (ce_a),
    .ce_b       (ce_b),
    .ce_c       (ce_c),
    .oe         (oe),
    .sleep      (sleep),
    .rdata      (rdata),
    .rdata_en   (rdata_en)
);

// File: tb/tb_sbsram_top.sv
module tb_sbsram_top;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          strobe_cpu = 1'b0;
    logic          strobe_ctl = 1'b0;
    logic          adv = 1'b0;
    logic          lin_mode = 1'b0;
    logic [3:0]    byte_we = '0;
    logic          all_we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          ce_a = 1'b1;
    logic          ce_b = 1'b1;
    logic          ce_c = 1'b1;
    logic          oe = 1'b1;
    logic          sleep = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_en;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    // Expected output two edges after each issued cycle
    logic          q0_c = 1'b0, q0_v = 1'b0, q1_c = 1'b0, q1_v = 1'b0;
    logic [DW-1:0] q0_d = '0, q1_d = '0;
    string         q0_t = "", q1_t = "";

    always #10 clk = ~clk;

    sbsram_top #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .strobe_cpu(strobe_cpu),
        .strobe_ctl(strobe_ctl), .adv(adv), .lin_mode(lin_mode),
        .byte_we(byte_we), .all_we(all_we), .wdata(wdata),
        .ce_a(ce_a), .ce_b(ce_b), .ce_c(ce_c), .oe(oe), .sleep(sleep),
        .rdata(rdata), .rdata_en(rdata_en)
    );

    typedef struct packed {
        logic       lin;
        logic [7:0] start;
        logic [1:0] b0, b1, b2, b3;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 8'd5,  2'd1, 2'd0, 2'd3, 2'd2},
        '{1'b0, 8'd14, 2'd2, 2'd3, 2'd0, 2'd1},
        '{1'b0, 8'd3,  2'd3, 2'd2, 2'd1, 2'd0},
        '{1'b1, 8'd9,  2'd1, 2'd2, 2'd3, 2'd0},
        '{1'b1, 8'd7,  2'd3, 2'd0, 2'd1, 2'd2},
        '{1'b1, 8'd12, 2'd0, 2'd1, 2'd2, 2'd3}
    };

    function automatic logic [31:0] pat(input logic [7:0] a);
        logic [7:0] t;
        t = a * 8'd3;
        return {8'hC3, a, a ^ 8'h5A, t};
    endfunction

    task automatic check_out(input logic v, input logic [31:0] d, input string tag);
        logic [31:0] want;
        want = v ? d : 32'h0;
        checks++;
        if (rdata_en !== v || rdata !== want) begin
            failures++;
            $display("FAIL %s: rdata_en=%0b rdata=%h expected rdata_en=%0b rdata=%h",
                     tag, rdata_en, rdata, v, want);
        end
    endtask

    task automatic tick(input logic c, input logic v, input logic [31:0] d, input string tag);
        @(posedge clk);
        @(negedge clk);
        if (q1_c) check_out(q1_v, q1_d, q1_t);
        q1_c = q0_c; q1_v = q0_v; q1_d = q0_d; q1_t = q0_t;
        q0_c = c;    q0_v = v;    q0_d = d;    q0_t = tag;
    endtask

    task automatic set_idle();
        strobe_cpu = 1'b0; strobe_ctl = 1'b0; adv = 1'b0;
        byte_we = '0; all_we = 1'b0; wdata = '0; addr = '0;
    endtask

    task automatic load_ctl(input logic [7:0] a, input logic c, input logic v,
                            input logic [31:0] d, input string tag);
        set_idle(); strobe_ctl = 1'b1; addr = a;
        tick(c, v, d, tag);
    endtask

    task automatic load_cpu(input logic [7:0] a, input logic c, input logic v,
                            input logic [31:0] d, input string tag);
        set_idle(); strobe_cpu = 1'b1; addr = a;
        tick(c, v, d, tag);
    endtask

    task automatic step(input logic [3:0] be, input logic awe, input logic [31:0] wd,
                        input logic c, input logic v, input logic [31:0] d, input string tag);
        set_idle(); adv = 1'b1; byte_we = be; all_we = awe; wdata = wd;
        tick(c, v, d, tag);
    endtask

    task automatic hold_write(input logic [3:0] be, input logic awe, input logic [31:0] wd,
                              input string tag);
        set_idle(); byte_we = be; all_we = awe; wdata = wd;
        tick(1'b1, 1'b0, 32'h0, tag);
    endtask

    task automatic nop(input logic c, input string tag);
        set_idle();
        tick(c, 1'b0, 32'h0, tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        string tg;
        logic [5:0] blk;

        // R1: reset state
        set_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out(1'b0, 32'h0, "R1 during reset");
        rst = 1'b0;
        nop(1'b0, "R1");
        check_out(1'b0, 32'h0, "R1 after reset");

        // Preload blocks 0..3 with pat(a), whole-word writes (R7)
        for (int b = 0; b < 4; b++) begin
            load_ctl(8'(b * 4), 1'b0, 1'b0, 32'h0, "R7");
            hold_write(4'h0, 1'b1, pat(8'(b * 4)), "R7");
            for (int n = 1; n < 4; n++)
                step(4'h0, 1'b1, pat(8'(b * 4 + n)), 1'b1, 1'b0, 32'h0, "R7");
        end
        nop(1'b1, "R2"); nop(1'b1, "R2");

        // R2: two-edge read latency, no early word
        load_ctl(8'd2, 1'b1, 1'b1, pat(8'd2), "R2");
        nop(1'b1, "R2"); nop(1'b1, "R2");

        // R3 / R4 / R5: burst orders and wrap, table driven
        for (int i = 0; i < 6; i++) begin
            lin_mode = VECS[i].lin;
            blk = VECS[i].start[7:2];
            tg = VECS[i].lin ? "R4" : "R3";
            load_ctl(VECS[i].start, 1'b1, 1'b1, pat({blk, VECS[i].b0}), tg);
            step(4'h0, 1'b0, 32'h0, 1'b1, 1'b1, pat({blk, VECS[i].b1}), tg);
            step(4'h0, 1'b0, 32'h0, 1'b1, 1'b1, pat({blk, VECS[i].b2}), tg);
            step(4'h0, 1'b0, 32'h0, 1'b1, 1'b1, pat({blk, VECS[i].b3}), tg);
            step(4'h0, 1'b0, 32'h0, 1'b1, 1'b1, pat({blk, VECS[i].b0}), "R5 wrap");
            nop(1'b1, tg);
        end
        lin_mode = 1'b0;

        // R6 / R7: byte writes and whole-word override
        load_ctl(8'd20, 1'b0, 1'b0, 32'h0, "R7");
        hold_write(4'h0, 1'b1, 32'h11223344, "R7");
        load_ctl(8'd20, 1'b0, 1'b0, 32'h0, "R6");
        hold_write(4'b0101, 1'b0, 32'hAABBCCDD, "R6");
        load_ctl(8'd20, 1'b1, 1'b1, 32'h11BB33DD, "R6");
        hold_write(4'b0001, 1'b1, 32'hDEADBEEF, "R7");
        load_ctl(8'd20, 1'b1, 1'b1, 32'hDEADBEEF, "R7");
        nop(1'b1, "R7"); nop(1'b1, "R7");

        // R8: processor strobe ignored while ce_a=0, burst continues
        lin_mode = 1'b1;
        load_ctl(8'd4, 1'b1, 1'b1, pat(8'd4), "R8");
        set_idle(); strobe_cpu = 1'b1; ce_a = 1'b0; addr = 8'd40;
        tick(1'b1, 1'b0, 32'h0, "R8 ignored");
        ce_a = 1'b1;
        step(4'h0, 1'b0, 32'h0, 1'b1, 1'b1, pat(8'd5), "R8 continue");
        load_cpu(8'd8, 1'b1, 1'b1, pat(8'd8), "R8 accepted");
        // R9: a load with write enables is still a read
        set_idle(); strobe_cpu = 1'b1; addr = 8'd9; all_we = 1'b1; wdata = 32'h0;
        tick(1'b1, 1'b1, pat(8'd9), "R9 load reads");
        load_ctl(8'd9, 1'b1, 1'b1, pat(8'd9), "R9 no write");
        nop(1'b1, "R9"); nop(1'b1, "R9");

        // R9: controller strobe loads with ce_a=0 and ends the burst
        load_ctl(8'd4, 1'b1, 1'b1, pat(8'd4), "R9");
        nop(1'b1, "R9");
        set_idle(); strobe_ctl = 1'b1; ce_a = 1'b0; addr = 8'd12;
        tick(1'b1, 1'b0, 32'h0, "R9 unselected");
        ce_a = 1'b1;
        step(4'h0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "R9 burst ended");
        nop(1'b1, "R9"); nop(1'b1, "R9");

        // R10: deselect drops the read accepted one cycle earlier
        load_ctl(8'd0, 1'b1, 1'b1, pat(8'd0), "R10");
        step(4'h0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "R10 dropped");
        set_idle(); strobe_ctl = 1'b1; ce_b = 1'b0; addr = 8'd8;
        tick(1'b1, 1'b0, 32'h0, "R10");
        ce_b = 1'b1;
        step(4'h0, 1'b0, 32'h0, 1'b1, 1'b0, 32'h0, "R10");
        load_ctl(8'd8, 1'b1, 1'b1, pat(8'd8), "R10 reselect");
        nop(1'b1, "R10"); nop(1'b1, "R10");

        // R11: output enable acts between edges
        load_ctl(8'd3, 1'b1, 1'b1, pat(8'd3), "R11");
        nop(1'b1, "R11"); nop(1'b1, "R11");
        oe = 1'b0;
        #2;
        check_out(1'b0, 32'h0, "R11 oe low");
        oe = 1'b1;
        #2;
        check_out(1'b1, pat(8'd3), "R11 oe high");

        // R12: sleep blanks output, blocks accesses, keeps contents
        load_ctl(8'd30, 1'b0, 1'b0, 32'h0, "R12");
        hold_write(4'h0, 1'b1, 32'h12345678, "R12");
        load_ctl(8'd30, 1'b1, 1'b0, 32'h0, "R12 masked");
        sleep = 1'b1;
        set_idle(); all_we = 1'b1; wdata = 32'hFFFFFFFF;
        tick(1'b1, 1'b0, 32'h0, "R12");
        set_idle(); strobe_ctl = 1'b1; addr = 8'd31;
        tick(1'b1, 1'b0, 32'h0, "R12");
        set_idle(); adv = 1'b1; all_we = 1'b1; wdata = 32'hFFFFFFFF;
        tick(1'b1, 1'b0, 32'h0, "R12");
        check_out(1'b0, 32'h0, "R12 asleep");
        sleep = 1'b0;
        load_ctl(8'd30, 1'b1, 1'b1, 32'h12345678, "R12 retained");
        nop(1'b1, "R12"); nop(1'b1, "R12"); nop(1'b1, "R12");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule